// File: doc/BRIEF.md
# Glitch-Free Multi-Clock Output Selector

This block selects one of N independent, unrelated input clocks, using a binary select code, and drives the chosen clock onto a single output. It is built from ordinary flip-flops and gates, with no dedicated clock-multiplexing cell. When the select code changes, the output never shows a shortened high or low pulse. The old clock is removed while it is low, and the output then rests low. The new clock is admitted only after every other lane has shut off.

Each input clock has its own lane. A lane is a three-stage enable chain: two stages that capture on the rising edge and a final stage that captures on the falling edge. The final stage gates that lane's clock. A lane may start arming only while the final stage of every other lane is low. The gated clocks are merged by an OR. A select code of N or more arms no lane, and the output stays low.

The design is register-driven rather than state-machine-driven. The only state is the two arming stages and one enable stage per lane, so there are no named states or transitions to list.

Top module: `clk_handover_mux`

## Requirements
- R1: With select code k < N held steady, the output follows input clock k, edge for edge, once the handover has completed.
- R2: A select code of N or more holds every lane's enable stage low within three rising edges of each clock, and the output stays low.
- R3: The enable stages of the lanes are never high in more than one lane at a time.
- R4: Every high pulse on the output is exactly one half-period of some input clock. No low pulse is shorter than the shortest input half-period.
- R5: A lane's enable stage changes only while that lane's clock is low. It holds steady through each high phase.
- R6: Each handover between two distinct valid codes behaves as follows. The output goes low on a falling edge of the old clock. It stays low for between two and three periods of the new clock, and then the new clock rises.
- R7: While the active-low reset is asserted, every lane is cleared and the output is low. After release, the selected clock appears within three of its periods.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset of all lane chains |
| clk_in | input | N | Input clocks, bit k is clock k |
| sel | input | max(1, ceil(log2 N)) | Binary code of the clock to forward |
| clk_out | output | 1 | Selected, glitch-free output clock |

## Verification
Two functions can fall on the same instant. The first is the old lane's enable stage dropping on a falling edge of the old clock. The second is the new lane's first arming stage sampling the interlock on a rising edge of the new clock. The bench provokes this coincidence with clocks of 5, 7 and 12.2 ns periods, whose edges meet at common multiples such as 17.5 ns and 35 ns, and by sweeping every ordered pair of select codes. Either resolution of the coincidence is accepted, provided the measured low gap stays within two to three new-clock periods and no output pulse is truncated.

// File: rtl/chm_pkg.sv
package chm_pkg;

    // Width of the binary select code for a given number of input clocks.
    function automatic int unsigned chm_sel_width(input int unsigned n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/chm_onehot.sv
module chm_onehot #(
    parameter int unsigned N  = 4,
    parameter int unsigned SW = 2
) (
    input  logic [SW-1:0] sel_i,
    output logic [N-1:0]  hot_o
);
    // One comparator per lane; codes of N or more match no lane.
    for (genvar k = 0; k < N; k++) begin : g_code
        localparam logic [SW-1:0] CODE = SW'(k);
        assign hot_o[k] = (sel_i == CODE);
    end
endmodule

// File: rtl/chm_lane.sv
module chm_lane (
    input  logic clk_i,
    input  logic rst_n,
    input  logic want_i,       // this lane is the one selected
    input  logic others_on_i,  // some other lane still has its enable stage high
    output logic en_o,         // final enable stage (falling-edge)
    output logic gated_o       // clock passed through when enabled
);
    logic arm_a;
    logic arm_b;

    // Arming stages on the rising edge. The chain input is forced low
    // while any other lane still drives the merge.
    always_ff @(posedge clk_i or negedge rst_n) begin
        if (!rst_n) begin
            arm_a <= 1'b0;
            arm_b <= 1'b0;
        end else begin
            arm_a <= want_i & ~others_on_i;
            arm_b <= arm_a;
        end
    end

    // The enable stage moves only while the clock is low.
    always_ff @(negedge clk_i or negedge rst_n) begin
        if (!rst_n) en_o <= 1'b0;
        else        en_o <= arm_b;
    end

    assign gated_o = clk_i & en_o;
endmodule

// File: rtl/chm_or_merge.sv
module chm_or_merge #(
    parameter int unsigned N = 4
) (
    input  logic [N-1:0] in_i,
    output logic         out_o
);
    // The interlock leaves at most one input active; a plain OR merges them.
    assign out_o = |in_i;
endmodule

// File: rtl/clk_handover_mux.sv
module clk_handover_mux
    import chm_pkg::*;
#(
    parameter  int unsigned N  = 4,
    localparam int unsigned SW = chm_sel_width(N)
) (
    input  logic          rst_n,
    input  logic [N-1:0]  clk_in,
    input  logic [SW-1:0] sel,
    output logic          clk_out
);
    logic [N-1:0] want;
    logic [N-1:0] lane_en;
    logic [N-1:0] gated;
    logic [N-1:0] others_on;

    chm_onehot #(.N(N), .SW(SW)) u_dec (
        .sel_i (sel),
        .hot_o (want)
    );

    for (genvar i = 0; i < N; i++) begin : g_lane
        localparam logic [N-1:0] OTHERS = ~(N'(1) << i);
        assign others_on[i] = |(lane_en & OTHERS);

        chm_lane u_lane (
            .clk_i       (clk_in[i]),
            .rst_n       (rst_n),
            .want_i      (want[i]),
            .others_on_i (others_on[i]),
            .en_o        (lane_en[i]),
            .gated_o     (gated[i])
        );
    end

    chm_or_merge #(.N(N)) u_merge (
        .in_i  (gated),
        .out_o (clk_out)
    );
endmodule

// File: rtl/chm_checker.sv
module chm_checker #(
    parameter int unsigned N  = 4,
    parameter int unsigned SW = 2
) (
    input logic          rst_n,
    input logic [N-1:0]  clk_in,
    input logic [SW-1:0] sel,
    input logic [N-1:0]  en_vec,
    input logic          clk_out
);
    logic bad_code;
    assign bad_code = ({1'b0, sel} >= (SW+1)'(N));

    for (genvar i = 0; i < N; i++) begin : g_chk
        logic en_at_rise;

        always_ff @(posedge clk_in[i] or negedge rst_n) begin
            if (!rst_n) en_at_rise <= 1'b0;
            else        en_at_rise <= en_vec[i];
        end

        // R3
        excl_enable_chk: assert property (@(posedge clk_in[i]) disable iff (!rst_n)
            $onehot0(en_vec));

        // R5
        quiet_high_phase_chk: assert property (@(negedge clk_in[i]) disable iff (!rst_n)
            1'b1 |-> (en_vec[i] == en_at_rise));

        // R2
        bad_select_off_chk: assert property (@(posedge clk_in[i]) disable iff (!rst_n)
            ($past(bad_code, 2) && $past(bad_code, 1) && bad_code) |-> !en_vec[i]);

        // R4
        idle_output_low_chk: assert property (@(posedge clk_in[i]) disable iff (!rst_n)
            (en_vec == '0) |-> !clk_out);
    end
endmodule

bind clk_handover_mux chm_checker #(.N(N), .SW(SW)) u_chk (
    .rst_n   (rst_n),
    .clk_in  (clk_in),
    .sel     (sel),
    .en_vec  (lane_en),
    .clk_out (clk_out)
);

// File: tb/clk_handover_mux_test.sv
`timescale 1ns/10ps
module clk_handover_mux_test;
    localparam int N = 3;

    logic c0, c1, c2;
    logic rst_n;
    logic [1:0] sel;
    logic [N-1:0] clks;
    logic clk_out;

    int total;
    int bad;
    int pulse_total;
    int pulse_bad;
    bit timed_out;
    realtime switch_time;

    assign clks = {c2, c1, c0};

    clk_handover_mux #(.N(N)) uut (
        .rst_n   (rst_n),
        .clk_in  (clks),
        .sel     (sel),
        .clk_out (clk_out)
    );

    // 200 MHz clock is input 0; the others are unrelated.
    initial begin c0 = 1'b0; forever #2.5 c0 = ~c0; end
    initial begin c1 = 1'b0; forever #3.5 c1 = ~c1; end
    initial begin c2 = 1'b0; forever #6.1 c2 = ~c2; end

    function automatic real half_of(input int v);
        case (v)
            0: return 2.5;
            1: return 3.5;
            default: return 6.1;
        endcase
    endfunction

    // Pulse monitor: R4 widths and the longest low gap since the last switch (R6).
    realtime last_rise, last_fall, max_low, mark;
    bit seen_fall;
    initial begin
        last_rise = 0; last_fall = 0; max_low = 0; mark = 0; seen_fall = 0;
        pulse_total = 0; pulse_bad = 0;
    end

    always @(posedge clk_out) begin
        realtime low;
        low = $realtime - last_fall;
        if (switch_time != mark) begin mark = switch_time; max_low = 0; end
        if (seen_fall && last_fall >= switch_time && low > max_low) max_low = low;
        if (seen_fall) begin
            pulse_total++;
            if (low < 2.5 - 0.02) begin
                pulse_bad++;
                $display("FAIL R4 low pulse: actual=%0.2f expected>=2.50", low);
            end
        end
        last_rise = $realtime;
    end

    always @(negedge clk_out) begin
        realtime hi;
        hi = $realtime - last_rise;
        pulse_total++;
        if (!((hi > 2.49 && hi < 2.51) || (hi > 3.49 && hi < 3.51) || (hi > 6.09 && hi < 6.11))) begin
            pulse_bad++;
            $display("FAIL R4/R5 high pulse: actual=%0.2f expected one of 2.50/3.50/6.10", hi);
        end
        last_fall = $realtime;
        seen_fall = 1'b1;
    end

    task automatic check(input bit ok, input string req, input string what,
                         input real act, input real exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0.2f expected=%0.2f", req, what, act, exp);
        end
    endtask

    // Compare output against the expected clock over 60 ns, sampled every 0.5 ns.
    task automatic window(input int v, input string req);
        int miss = 0;
        for (int s = 0; s < 120; s++) begin
            logic exp_bit;
            exp_bit = (v < N) ? clks[v] : 1'b0;
            if (clk_out !== exp_bit) miss++;
            #0.5;
        end
        check(miss == 0, req, $sformatf("output vs code %0d mismatching samples", v), miss, 0);
    endtask

    int prev;

    task automatic step(input int v);
        if (v != prev) begin
            sel = 2'(v);
            switch_time = $realtime;
        end
        #100;
        if (v < N) window(v, "R1");
        else       window(v, "R2");
        if (prev != v && prev < N && v < N) begin
            real p;
            p = 2.0 * half_of(v);
            // R6: low gap between two and three new-clock periods
            check(max_low >= 2.0 * p - 0.02 && max_low <= 3.0 * p + 0.02, "R6",
                  $sformatf("gap %0d->%0d", prev, v), max_low, 2.5 * p);
        end
        prev = v;
    endtask

    task automatic run_all();
        int hi_seen = 0;
        rst_n = 1'b0;
        sel = 2'd0;
        switch_time = 0;
        #0.05;
        // R7: output low throughout reset
        for (int s = 0; s < 40; s++) begin
            if (clk_out !== 1'b0) hi_seen++;
            #0.5;
        end
        check(hi_seen == 0, "R7", "output high samples in reset", hi_seen, 0);
        rst_n = 1'b1;
        prev = 0;
        // R7: clock 0 appears after release (first step, no switch)
        step(0);
        // R1 R2 R6: every ordered pair of codes, including the invalid code 3
        for (int a = 0; a < 4; a++) begin
            for (int b = 0; b < 4; b++) begin
                if (a != b) begin
                    step(a);
                    step(b);
                end
            end
        end
    endtask

    initial begin
        total = 0; bad = 0; timed_out = 1'b0;
        fork
            run_all();
            begin #50000; timed_out = 1'b1; end
        join_any
        disable fork;
        if (timed_out) begin
            total++; bad++;
            $display("FAIL watchdog: actual=expired expected=done");
        end
        // R4: fold pulse monitor into the totals
        total += pulse_total;
        bad += pulse_bad;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule